// File: doc/BRIEF.md
# NAND-Style ROM Command and Address Front End

This block is the device-side control logic of a read-only memory that talks to its host over a multiplexed 8-bit bus in the NAND manner. The host writes bytes with a write strobe. A command-latch or address-latch qualifier tells whether a byte is a command or part of an address. The block keeps a small read-command set. It builds a 25-bit array address from three address bytes and a command-chosen half-page bit. It then raises a request to the storage array and shows busy until the array acknowledges.

Once ready, each falling edge of the read strobe registers one byte on the output and advances the address, so a host can stream a page sequentially. One read mode serves the spare area: it uses only the low nibble of the first address byte and returns FFh for every byte. A reset command works at any time. It is the only command honoured while busy.

All strobes are sampled on the block clock. The host must hold each strobe level for at least one clock.

Top module: `nrom_front`

## Requirements
- R1: Command 00h selects the lower half-page (A8 = 0), command 01h selects the upper half-page (A8 = 1), and command 50h selects the spare-area mode (A8 = 0). Any other code except FFh is ignored and leaves the mode and the latched command unchanged.
- R2: After a read command, three address bytes form the array address. Byte 1 gives bits 7..0, byte 2 gives bits 16..9 and byte 3 gives bits 24..17, and bit 8 comes from R1.
- R3: In spare-area mode, only bits 3..0 of address byte 1 are used. Bits 7..4 of that byte have no effect, and address bits 7..4 are 0.
- R4: The clock edge that takes the third address byte drives `rdy` low and `arr_req` high, with `arr_addr` holding the assembled address. `arr_addr` stays stable while the request is pending. The edge on which `arr_ack` is seen with the request high drives `rdy` high and `arr_req` low.
- R5: While busy, a command byte other than FFh and any address byte have no effect on mode, address or request.
- R6: When ready, with an address complete, each falling edge of `re_n` registers the array byte at `arr_addr` onto `io_out` and then increments `arr_addr` by one, wrapping modulo 2^25.
- R7: In spare-area mode, every byte read drives `io_out` to FFh, whatever the array data.
- R8: Command FFh, accepted even when busy, clears the request and busy on the clock edge that takes it. It also sets `arr_addr` to 0, restores the lower half-page mode and discards the latched read command, so later reads leave `io_out` unchanged. After `rst_n`, `rdy` = 1, `arr_req` = 0 and `io_out` = 00h.
- R9: Address bytes with no read command latched, and address bytes after the third, are ignored.
- R10: A byte is taken only on a rising edge of `we_n`: as a command when `cle` = 1 and `ale` = 0, and as an address when `ale` = 1 and `cle` = 0. A byte strobed with both qualifiers high or both low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cle | input | 1 | Command-latch qualifier |
| ale | input | 1 | Address-latch qualifier |
| we_n | input | 1 | Write strobe, byte taken on its rising edge |
| re_n | input | 1 | Read strobe, byte presented on its falling edge |
| io_in | input | 8 | Host command or address byte |
| io_out | output | 8 | Registered read data byte |
| rdy | output | 1 | Ready (1) or busy (0) |
| arr_req | output | 1 | Read request to the storage array |
| arr_addr | output | 25 | Current array address |
| arr_ack | input | 1 | Array acknowledge, ends the request |
| arr_data | input | 8 | Array byte at `arr_addr` |

## Verification
On every cycle, the assertions check the following:
- the busy/request entry after the third address byte, and the release on acknowledge or reset;
- that the address does not move while the request is pending;
- the one-step address advance per read;
- the FFh override in spare-area mode;
- that non-reset commands leave the mode alone while busy;
- that the half-page bit follows the command.

Only the bench scenarios can show the following:
- the exact bit placement of the three address bytes and the masked nibble;
- the data streamed against an array model;
- that stray, extra or badly qualified bytes change nothing visible at the ports.

// File: rtl/nrom_pkg.sv
package nrom_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 25;

  typedef enum logic [1:0] {
    RM_HALF0 = 2'd0,
    RM_HALF1 = 2'd1,
    RM_TAIL  = 2'd2
  } rm_e;

  typedef struct packed {
    logic is_read;
    logic is_reset;
    rm_e  mode;
  } cmd_dec_t;

  function automatic cmd_dec_t decode_cmd(input logic [BYTE_W-1:0] b);
    cmd_dec_t d;
    d.is_read  = 1'b0;
    d.is_reset = 1'b0;
    d.mode     = RM_HALF0;
    case (b)
      8'h00: begin d.is_read = 1'b1; d.mode = RM_HALF0; end
      8'h01: begin d.is_read = 1'b1; d.mode = RM_HALF1; end
      8'h50: begin d.is_read = 1'b1; d.mode = RM_TAIL;  end
      8'hFF: d.is_reset = 1'b1;
      default: ;
    endcase
    return d;
  endfunction

  // Place the three address bytes around the command-chosen bit 8.
  function automatic logic [ADDR_W-1:0] assemble_addr(
    input logic [BYTE_W-1:0] lo,
    input logic [BYTE_W-1:0] mid,
    input logic [BYTE_W-1:0] hi,
    input logic              half_bit,
    input logic              nib_only);
    logic [BYTE_W-1:0] lo_m;
    lo_m = nib_only ? {4'h0, lo[3:0]} : lo;
    return {hi, mid, half_bit, lo_m};
  endfunction

  function automatic logic [BYTE_W-1:0] out_byte(
    input logic              tail_mode,
    input logic [BYTE_W-1:0] data);
    return tail_mode ? {BYTE_W{1'b1}} : data;
  endfunction
endpackage

// File: rtl/nrom_edge.sv
module nrom_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic evt
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= strobe;
  end

  generate
    if (RISING) begin : g_rise
      assign evt = strobe & ~prev_q;
    end else begin : g_fall
      assign evt = ~strobe & prev_q;
    end
  endgenerate
endmodule

// File: rtl/nrom_cmd_ctl.sv
module nrom_cmd_ctl
  import nrom_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_evt,
  input  logic [BW-1:0] cmd_byte,
  input  logic          addr_third,
  input  logic          arr_ack,
  output rm_e           mode,
  output logic          cmd_valid,
  output logic          busy,
  output logic          reset_evt,
  output logic          read_cmd_evt
);
  cmd_dec_t dec;

  always_comb begin
    dec          = decode_cmd(cmd_byte);
    reset_evt    = cmd_evt & dec.is_reset;
    read_cmd_evt = cmd_evt & dec.is_read & ~busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= RM_HALF0;
      cmd_valid <= 1'b0;
    end else if (reset_evt) begin
      mode      <= RM_HALF0;
      cmd_valid <= 1'b0;
    end else if (read_cmd_evt) begin
      mode      <= dec.mode;
      cmd_valid <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy <= 1'b0;
    else if (reset_evt)  busy <= 1'b0;
    else if (addr_third) busy <= 1'b1;
    else if (arr_ack)    busy <= 1'b0;
  end
endmodule

// File: rtl/nrom_addr_asm.sv
module nrom_addr_asm
  import nrom_pkg::*;
#(
  parameter int BW  = BYTE_W,
  parameter int AW  = ADDR_W,
  parameter int NCY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          take,
  input  logic [BW-1:0] byte_in,
  input  logic          half_bit,
  input  logic          nib_only,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          complete,
  output logic          third
);
  localparam int CW = $clog2(NCY + 1);
  localparam logic [CW-1:0] LAST = CW'(NCY - 1);
  localparam logic [CW-1:0] DONE = CW'(NCY);

  logic [CW-1:0] cyc;
  logic [BW-1:0] b_lo, b_mid;
  logic          take_ok;

  assign take_ok  = take & (cyc != DONE);
  assign third    = take_ok & (cyc == LAST);
  assign complete = (cyc == DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc   <= '0;
      addr  <= '0;
      b_lo  <= '0;
      b_mid <= '0;
    end else if (clear) begin
      cyc  <= '0;
      addr <= '0;
    end else if (take_ok) begin
      cyc <= cyc + CW'(1);
      if (cyc == CW'(0)) b_lo  <= byte_in;
      if (cyc == CW'(1)) b_mid <= byte_in;
      if (third) addr <= assemble_addr(b_lo, b_mid, byte_in, half_bit, nib_only);
    end else if (step) begin
      addr <= addr + AW'(1);
    end
  end
endmodule

// File: rtl/nrom_front.sv
module nrom_front
  import nrom_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cle,
  input  logic          ale,
  input  logic          we_n,
  input  logic          re_n,
  input  logic [BW-1:0] io_in,
  output logic [BW-1:0] io_out,
  output logic          rdy,
  output logic          arr_req,
  output logic [AW-1:0] arr_addr,
  input  logic          arr_ack,
  input  logic [BW-1:0] arr_data
);
  logic we_rise, re_fall;
  logic cmd_evt, addr_evt, addr_third, addr_complete;
  logic reset_evt, read_cmd_evt, cmd_valid, busy, read_evt, tail_mode;
  rm_e  mode;

  nrom_edge #(.RISING(1'b1)) u_we_edge (
    .clk(clk), .rst_n(rst_n), .strobe(we_n), .evt(we_rise));
  nrom_edge #(.RISING(1'b0)) u_re_edge (
    .clk(clk), .rst_n(rst_n), .strobe(re_n), .evt(re_fall));

  assign cmd_evt  = we_rise &  cle & ~ale;
  assign addr_evt = we_rise &  ale & ~cle;

  nrom_cmd_ctl #(.BW(BW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_evt(cmd_evt), .cmd_byte(io_in),
    .addr_third(addr_third), .arr_ack(arr_ack), .mode(mode),
    .cmd_valid(cmd_valid), .busy(busy), .reset_evt(reset_evt),
    .read_cmd_evt(read_cmd_evt));

  assign tail_mode = (mode == RM_TAIL);
  assign read_evt  = re_fall & cmd_valid & addr_complete & ~busy;

  nrom_addr_asm #(.BW(BW), .AW(AW), .NCY(3)) u_addr (
    .clk(clk), .rst_n(rst_n), .clear(reset_evt | read_cmd_evt),
    .take(addr_evt & cmd_valid & ~busy), .byte_in(io_in),
    .half_bit(mode == RM_HALF1), .nib_only(tail_mode), .step(read_evt),
    .addr(arr_addr), .complete(addr_complete), .third(addr_third));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        io_out <= '0;
    else if (read_evt) io_out <= out_byte(tail_mode, arr_data);
  end

  assign arr_req = busy;
  assign rdy     = ~busy;
endmodule

// File: rtl/nrom_front_chk.sv
module nrom_front_chk
  import nrom_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int AW = ADDR_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cle,
  input logic          ale,
  input logic          cmd_evt,
  input logic          reset_evt,
  input logic          addr_third,
  input logic          read_evt,
  input logic          busy,
  input rm_e           mode,
  input logic [BW-1:0] io_out,
  input logic          rdy,
  input logic          arr_req,
  input logic          arr_ack,
  input logic [AW-1:0] arr_addr
);
  p_third_enters_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_third |=> (!rdy && arr_req));

  p_addr_hold_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && !arr_ack && !reset_evt) |=> $stable(arr_addr));

  p_ack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && arr_ack) |=> (rdy && !arr_req));

  p_reset_cmd_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_evt |=> (rdy && !arr_req && arr_addr == '0));

  p_busy_keeps_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_evt && busy && !reset_evt && !arr_ack) |=> ($stable(mode) && arr_req));

  p_stream_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    read_evt |=> (arr_addr == AW'($past(arr_addr) + AW'(1))));

  p_tail_ff_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (read_evt && mode == RM_TAIL) |=> (io_out == {BW{1'b1}}));

  p_half_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_third |=> (arr_addr[8] == (mode == RM_HALF1)));

  p_addr_qual_r10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_third |-> (ale && !cle));
endmodule

bind nrom_front nrom_front_chk #(.BW(BW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .cmd_evt(cmd_evt),
  .reset_evt(reset_evt), .addr_third(addr_third), .read_evt(read_evt),
  .busy(busy), .mode(mode), .io_out(io_out), .rdy(rdy), .arr_req(arr_req),
  .arr_ack(arr_ack), .arr_addr(arr_addr));

// File: tb/nrom_front_tb.sv
`timescale 1ns/1ps
module nrom_front_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
  logic [7:0]  io_in = 8'h00;
  logic [7:0]  io_out;
  logic        rdy, arr_req, arr_ack = 1'b0;
  logic [24:0] arr_addr;
  logic [7:0]  arr_data;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  bit ack_en = 1'b1;
  int ack_delay = 2;
  int wait_cnt = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [24:0] a);
    return a[7:0] ^ {a[12:9], a[16:13]} ^ a[24:17] ^ (a[8] ? 8'h3C : 8'h00);
  endfunction

  // Expected address, built with arithmetic rather than concatenation.
  function automatic logic [24:0] exp_addr(input logic [7:0] cmd,
      input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3);
    int v;
    v = b3 * 131072 + b2 * 512 + ((cmd == 8'h01) ? 256 : 0)
      + ((cmd == 8'h50) ? (b1 % 16) : b1);
    return 25'(v);
  endfunction

  assign arr_data = mem_byte(arr_addr);

  nrom_front u_dut (
    .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .io_in(io_in), .io_out(io_out), .rdy(rdy), .arr_req(arr_req),
    .arr_addr(arr_addr), .arr_ack(arr_ack), .arr_data(arr_data));

  // Array model: acknowledge after ack_delay cycles of pending request.
  always @(negedge clk) begin
    arr_ack <= 1'b0;
    if (arr_req && ack_en) begin
      if (wait_cnt >= ack_delay) begin
        arr_ack  <= 1'b1;
        wait_cnt <= 0;
      end else wait_cnt <= wait_cnt + 1;
    end else wait_cnt <= 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] b);
    @(negedge clk); cle = c; ale = a; io_in = b; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b);  wr(1'b1, 1'b0, b); endtask
  task automatic adr(input logic [7:0] b);  wr(1'b0, 1'b1, b); endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); re_n = 1'b1;
    v = io_out;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 60 && !rdy; i++) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] c, input logic [7:0] b1,
                      input logic [7:0] b2, input logic [7:0] b3);
    cmd(c); adr(b1); adr(b2); adr(b3);
  endtask

  task automatic stream(input string req, input logic [7:0] c,
                        input logic [24:0] a0, input int n);
    logic [7:0]  v;
    logic [24:0] a;
    a = a0;
    for (int k = 0; k < n; k++) begin
      rd(v);
      chk(req, v, (c == 8'h50) ? 8'hFF : mem_byte(a));
      a = a + 25'd1;
      chk("R6 addr step", arr_addr, a);
    end
  endtask

  initial begin
    logic [7:0]  v, b1, b2, b3, c;
    logic [24:0] ea;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset rdy", rdy, 1);
    chk("R8 reset req", arr_req, 0);
    chk("R8 reset io_out", io_out, 8'h00);

    // R10: badly qualified command strobes, then address bytes: all ignored (R9).
    wr(1'b1, 1'b1, 8'h00);
    wr(1'b0, 1'b0, 8'h00);
    adr(8'h11); adr(8'h22); adr(8'h33);
    chk("R10 no cmd taken, rdy", rdy, 1);
    chk("R9 no cmd addr ignored", arr_addr, 0);

    // R1/R2/R4: lower half-page.
    ack_en = 1'b0;
    load(8'h00, 8'hA5, 8'h3C, 8'hE7);
    ea = exp_addr(8'h00, 8'hA5, 8'h3C, 8'hE7);
    chk("R4 busy after third", rdy, 0);
    chk("R4 req after third", arr_req, 1);
    chk("R2 addr assembly A8=0", arr_addr, ea);
    // R5: commands and address bytes while busy are ignored.
    cmd(8'h50); cmd(8'h01); adr(8'h99);
    chk("R5 addr unchanged while busy", arr_addr, ea);
    chk("R5 still busy", arr_req, 1);
    ack_en = 1'b1;
    wait_ready();
    chk("R4 ready after ack", rdy, 1);
    stream("R5/R6 lower half data", 8'h00, ea, 4);

    // R9: fourth address byte ignored; R1 unknown command ignored.
    adr(8'h5E);
    chk("R9 extra addr byte ignored", arr_addr, ea + 25'd4);
    cmd(8'h30);
    stream("R1 unknown cmd keeps stream", 8'h00, ea + 25'd4, 1);

    // R1: upper half-page sets A8.
    load(8'h01, 8'h10, 8'h02, 8'h01);
    wait_ready();
    chk("R1 A8=1 for 01h", arr_addr, exp_addr(8'h01, 8'h10, 8'h02, 8'h01));
    stream("R6 upper half data", 8'h01, exp_addr(8'h01, 8'h10, 8'h02, 8'h01), 2);

    // R3/R7: spare mode, high nibble junk.
    load(8'h50, 8'hF6, 8'h81, 8'h42);
    wait_ready();
    chk("R3 nibble mask", arr_addr, exp_addr(8'h50, 8'h06, 8'h81, 8'h42));
    stream("R7 spare FF", 8'h50, exp_addr(8'h50, 8'hF6, 8'h81, 8'h42), 3);
    cmd(8'h30);
    stream("R1 unknown keeps spare mode", 8'h50, exp_addr(8'h50, 8'hF6, 8'h81, 8'h42) + 25'd3, 1);

    // R8: reset command while busy.
    ack_en = 1'b0;
    load(8'h01, 8'h12, 8'h34, 8'h56);
    chk("R8 busy before reset", rdy, 0);
    @(negedge clk); cle = 1'b1; io_in = 8'hFF; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); cle = 1'b0;
    chk("R8 rdy one edge after FF", rdy, 1);
    chk("R8 req dropped", arr_req, 0);
    chk("R8 addr cleared", arr_addr, 0);
    ack_en = 1'b1;
    v = io_out;
    rd(v);
    chk("R8 read after reset leaves io_out", v, 8'hFF);
    adr(8'h01); adr(8'h02); adr(8'h03);
    chk("R8 cmd discarded, addr ignored", rdy, 1);
    chk("R8 cmd discarded, addr stays 0", arr_addr, 0);
    // Reset restores the lower half-page mode.
    adr(8'h00);
    load(8'h00, 8'h07, 8'h00, 8'h00);
    wait_ready();
    chk("R8 mode back to lower half", arr_addr, 25'd7);

    // Random runs.
    for (int it = 0; it < 24; it++) begin
      int sel;
      sel = $urandom_range(0, 2);
      c  = (sel == 0) ? 8'h00 : (sel == 1) ? 8'h01 : 8'h50;
      b1 = 8'($urandom); b2 = 8'($urandom); b3 = 8'($urandom);
      ack_delay = $urandom_range(0, 6);
      load(c, b1, b2, b3);
      wait_ready();
      ea = exp_addr(c, b1, b2, b3);
      chk("R2 random addr", arr_addr, ea);
      stream((c == 8'h50) ? "R7 random spare" : "R6 random data", c, ea,
             $urandom_range(1, 6));
    end

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule